// File: doc/BRIEF.md
# Swept-Threshold Range-Bin Frame Accumulator

This block assembles a multi-bit radar frame out of single-bit comparator results. The comparator checks the received echo against a threshold voltage. The block drives the digital code for that threshold and steps it from a programmable low code up to a programmable high code. For every transmitted pulse, the time-interleaved samplers deliver one or more 12-bit vectors. Each bit is the decision for one range bin. The block adds every bit into a counter owned by that range bin, so when the sweep is over each counter holds the number of threshold levels the echo exceeded, summed over the pulses.

A start request latches the sweep limits and the pulses-per-step count, clears all bin counters and raises busy. After the configured number of pulses at a code, the code rises by one. After the last pulse at the high code, busy falls and done pulses for one cycle. The frame can then be read one bin at a time by address until the next start. Narrowing the limits shortens the sweep in proportion and changes nothing else.

Top module: `st_frame_accum`

## Requirements
- R1: After reset, busy and done are 0, the threshold code is 0 and every bin reads 0.
- R2: A start with busy low sets busy to 1 and the threshold code to the low limit on the next clock edge. The same edge clears every bin counter to 0.
- R3: While busy, each vector strobe adds bit `l` of the sample vector to bin `g*LANES + l`, where `g` is the group index given with the strobe.
- R4: A pulse is complete when a strobe carries the last group index (GROUPS-1). After pulses-per-step complete pulses at one code, the code rises by exactly 1.
- R5: A pulses-per-step value of 0 behaves as 1.
- R6: The completing pulse at the high limit ends the sweep. On the following edge busy falls, and done is high for exactly one cycle. A sweep holds pulses-per-step × (high − low + 1) pulses.
- R7: A start while busy is ignored. The code sequence, the latched limits and the counters continue unchanged.
- R8: Vector strobes while not busy are ignored. The frame and the threshold code hold until the next start.
- R9: Counters are CODE_W+PPS_W bits wide, so a bin that sees a 1 on every pulse of a full-range sweep with the largest pulses-per-step reads that full count without wrapping.
- R10: A read address at or above GROUPS×LANES returns 0.
- R11: With the high limit equal to or below the low limit, the sweep runs a single step at the low code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sweep start request |
| lo_code | input | CODE_W | Low sweep limit |
| hi_code | input | CODE_W | High sweep limit |
| pulses_per_step | input | PPS_W | Pulses accumulated per threshold code |
| vec_valid | input | 1 | Sample vector strobe |
| vec_group | input | GRP_W | Range-bin group of this vector |
| vec_bits | input | LANES | One comparator decision per lane |
| rd_bin | input | BIN_W | Frame read address |
| dac_code | output | CODE_W | Threshold code for the DAC |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| rd_data | output | CNT_W | Count of the addressed bin |

## Verification
The threshold code, busy and the bin counters are all registered. Each of them therefore changes on the first clock edge after the strobe or start that moves it, and done follows the completing strobe by that same single edge. The read port is combinational, so a bin value can be checked a short delay after the read address is set. The bench drives inputs on falling edges and checks on the next falling edge. This means every expected code, flag and count is compared exactly one edge after its cause. Done is also checked to have dropped one cycle later.

// File: rtl/st_pkg.sv
package st_pkg;
  // A zero pulses-per-step setting is treated as one.
  function automatic logic [31:0] eff_pps(input logic [31:0] pps);
    return (pps == 0) ? 32'd1 : pps;
  endfunction

  // Number of threshold steps for given limits (single step if hi <= lo).
  function automatic logic [31:0] sweep_steps(input logic [31:0] lo, input logic [31:0] hi);
    return (hi > lo) ? (hi - lo + 32'd1) : 32'd1;
  endfunction

  // Width that holds the largest possible per-bin count.
  function automatic int count_width(input int code_w, input int pps_w);
    return code_w + pps_w;
  endfunction
endpackage

// File: rtl/st_sweep_seq.sv
module st_sweep_seq #(
  parameter int CODE_W = 6,
  parameter int PPS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] lo_code,
  input  logic [CODE_W-1:0] hi_code,
  input  logic [PPS_W-1:0]  pulses_per_step,
  input  logic              pulse_end,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] dac_code,
  output logic              clear,
  output logic              step_evt,
  output logic              last_evt,
  output logic [PPS_W-1:0]  pcnt,
  output logic [PPS_W-1:0]  pps_eff
);
  logic              busy_q, done_q;
  logic [CODE_W-1:0] code_q, hi_q;
  logic [PPS_W-1:0]  pps_q, pcnt_q;
  logic              step_end;

  assign clear    = start & ~busy_q;
  assign step_end = pulse_end && (pcnt_q == pps_q - PPS_W'(1));
  assign last_evt = step_end && (code_q >= hi_q);
  assign step_evt = step_end && !last_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      code_q <= '0;
      hi_q   <= '0;
      pps_q  <= PPS_W'(1);
      pcnt_q <= '0;
    end else begin
      done_q <= last_evt;
      if (clear) begin
        busy_q <= 1'b1;
        code_q <= lo_code;
        hi_q   <= hi_code;
        pps_q  <= PPS_W'(st_pkg::eff_pps(32'(pulses_per_step)));
        pcnt_q <= '0;
      end else if (pulse_end) begin
        pcnt_q <= step_end ? '0 : pcnt_q + PPS_W'(1);
        if (step_evt) code_q <= code_q + CODE_W'(1);
        if (last_evt) busy_q <= 1'b0;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign dac_code = code_q;
  assign pcnt     = pcnt_q;
  assign pps_eff  = pps_q;
endmodule

// File: rtl/st_bin_bank.sv
module st_bin_bank #(
  parameter int LANES  = 12,
  parameter int GROUPS = 4,
  parameter int CNT_W  = 10,
  parameter int GRP_W  = 2,
  parameter int BIN_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             acc_en,
  input  logic [GRP_W-1:0] group,
  input  logic [LANES-1:0] bits,
  input  logic [BIN_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam int NBINS = LANES * GROUPS;
  logic [CNT_W-1:0] cnt [NBINS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt[g*LANES+l] <= '0;
        else if (clear)              cnt[g*LANES+l] <= '0;
        else if (acc_en && group == GRP_W'(g) && bits[l])
                                     cnt[g*LANES+l] <= cnt[g*LANES+l] + CNT_W'(1);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NBINS; i++)
      if (rd_addr == BIN_W'(i)) rd_data = cnt[i];
  end
endmodule

// File: rtl/st_frame_accum.sv
module st_frame_accum #(
  parameter int LANES  = 12,
  parameter int GROUPS = 4,
  parameter int CODE_W = 6,
  parameter int PPS_W  = 4,
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int BIN_W = $clog2(LANES * GROUPS) + 1,
  localparam int CNT_W = st_pkg::count_width(CODE_W, PPS_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] lo_code,
  input  logic [CODE_W-1:0] hi_code,
  input  logic [PPS_W-1:0]  pulses_per_step,
  input  logic              vec_valid,
  input  logic [GRP_W-1:0]  vec_group,
  input  logic [LANES-1:0]  vec_bits,
  input  logic [BIN_W-1:0]  rd_bin,
  output logic [CODE_W-1:0] dac_code,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  rd_data
);
  logic             clear, step_evt, last_evt, acc_en, pulse_end;
  logic [PPS_W-1:0] pcnt, pps_eff;

  assign acc_en    = vec_valid & busy;
  assign pulse_end = acc_en && (vec_group == GRP_W'(GROUPS - 1));

  st_sweep_seq #(.CODE_W(CODE_W), .PPS_W(PPS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .lo_code(lo_code),
    .hi_code(hi_code), .pulses_per_step(pulses_per_step),
    .pulse_end(pulse_end), .busy(busy), .done(done), .dac_code(dac_code),
    .clear(clear), .step_evt(step_evt), .last_evt(last_evt),
    .pcnt(pcnt), .pps_eff(pps_eff)
  );

  st_bin_bank #(.LANES(LANES), .GROUPS(GROUPS), .CNT_W(CNT_W),
                .GRP_W(GRP_W), .BIN_W(BIN_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clear(clear), .acc_en(acc_en),
    .group(vec_group), .bits(vec_bits), .rd_addr(rd_bin), .rd_data(rd_data)
  );
endmodule

// File: rtl/st_frame_accum_chk.sv
module st_frame_accum_chk #(
  parameter int CODE_W = 6,
  parameter int PPS_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] dac_code,
  input logic [CODE_W-1:0] lo_code,
  input logic              clear,
  input logic              step_evt,
  input logic              last_evt,
  input logic [PPS_W-1:0]  pcnt,
  input logic [PPS_W-1:0]  pps_eff
);
  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> busy && dac_code == $past(lo_code));

  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (dac_code - $past(dac_code)) == CODE_W'(1));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step_evt && !last_evt |=> busy && $stable(dac_code));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy && $stable(dac_code));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pcnt < pps_eff);
endmodule

bind st_frame_accum st_frame_accum_chk #(.CODE_W(CODE_W), .PPS_W(PPS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .dac_code(dac_code), .lo_code(lo_code), .clear(clear),
  .step_evt(step_evt), .last_evt(last_evt), .pcnt(pcnt), .pps_eff(pps_eff)
);

// File: tb/tb_st_frame_accum.sv
`timescale 1ns/1ps
module tb_st_frame_accum;
  localparam int LANES = 12, GROUPS = 4, CODE_W = 6, PPS_W = 4;
  localparam int NBINS = LANES * GROUPS;
  localparam int GRP_W = 2, BIN_W = 7, CNT_W = 10;

  logic clk = 0, rst_n = 0, start = 0, vec_valid = 0;
  logic [CODE_W-1:0] lo_code = 0, hi_code = 0, dac_code;
  logic [PPS_W-1:0]  pulses_per_step = 0;
  logic [GRP_W-1:0]  vec_group = 0;
  logic [LANES-1:0]  vec_bits = 0;
  logic [BIN_W-1:0]  rd_bin = 0;
  logic busy, done;
  logic [CNT_W-1:0] rd_data;

  int checks = 0, fails = 0;
  int expv [NBINS];
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  st_frame_accum dut (.*);

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic check_frame(input string req);
    for (int i = 0; i < NBINS; i++) begin
      rd_bin = BIN_W'(i);
      #0.5;
      chk(req, int'(rd_data), expv[i]);
    end
  endtask

  // All timing: drive at negedge, check at the following negedge.
  task automatic run_sweep(input int lo, input int hi, input int pps,
                           input bit all_ones, input bit poke_start);
    int eff, steps, total;
    eff   = (pps == 0) ? 1 : pps;
    steps = (hi > lo) ? hi - lo + 1 : 1;
    total = eff * steps;
    lo_code = CODE_W'(lo); hi_code = CODE_W'(hi);
    pulses_per_step = PPS_W'(pps);
    start = 1;
    @(posedge clk); @(negedge clk);
    start = 0;
    chk("R2 busy", int'(busy), 1);
    chk("R2 code", int'(dac_code), lo);
    for (int i = 0; i < NBINS; i++) expv[i] = 0;
    rd_bin = 0; #0.5; chk("R2 clear", int'(rd_data), 0);
    rd_bin = BIN_W'(NBINS - 1); #0.5; chk("R2 clear", int'(rd_data), 0);
    for (int p = 0; p < total; p++) begin
      chk((eff == 1 && pps == 0) ? "R5 code" : "R4 code", int'(dac_code), lo + p / eff);
      chk("R6 busy", int'(busy), 1);
      for (int g = 0; g < GROUPS; g++) begin
        rng = nxt(rng);
        vec_valid = 1;
        vec_group = GRP_W'(g);
        vec_bits  = all_ones ? '1 : rng[LANES-1:0];
        if (poke_start && p == 1 && g == 0) begin
          start = 1; lo_code = CODE_W'(lo + 5); hi_code = CODE_W'(lo);
          pulses_per_step = PPS_W'(eff + 1);
        end
        @(posedge clk); @(negedge clk);
        start = 0;
        for (int l = 0; l < LANES; l++) expv[g*LANES+l] += int'(vec_bits[l]);
        if (p < total - 1 || g < GROUPS - 1)
          chk("R6 no early done", int'(done), 0);
      end
    end
    vec_valid = 0;
    chk("R6 done", int'(done), 1);
    chk("R6 busy low", int'(busy), 0);
    if (poke_start) chk("R7 final code", int'(dac_code), (hi > lo) ? hi : lo);
    else chk((hi <= lo) ? "R11 code" : "R6 code", int'(dac_code), (hi > lo) ? hi : lo);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
    check_frame(all_ones ? "R9 count" : (poke_start ? "R7 frame" : "R3 frame"));
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < NBINS; i++) expv[i] = 0;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 code", int'(dac_code), 0);
    check_frame("R1 bins");
    @(negedge clk); rst_n = 1; @(negedge clk);

    run_sweep(3, 6, 2, 0, 0);   // R3 R4 R6 random bits
    run_sweep(20, 22, 3, 0, 1); // R7 start mid-sweep
    run_sweep(10, 10, 3, 0, 0); // R11 single step
    run_sweep(9, 4, 2, 0, 0);   // R11 hi below lo
    run_sweep(2, 5, 0, 0, 0);   // R5 zero pulses-per-step

    // R8: strobes while idle leave frame and code unchanged
    for (int g = 0; g < GROUPS; g++) begin
      vec_valid = 1; vec_group = GRP_W'(g); vec_bits = '1;
      @(posedge clk); @(negedge clk);
    end
    vec_valid = 0;
    chk("R8 idle busy", int'(busy), 0);
    chk("R8 idle code", int'(dac_code), 5);
    check_frame("R8 frame hold");

    // R10: out-of-range reads
    rd_bin = BIN_W'(NBINS); #0.5; chk("R10 oob", int'(rd_data), 0);
    rd_bin = '1;            #0.5; chk("R10 oob", int'(rd_data), 0);

    run_sweep(0, 63, 15, 1, 0); // R9 full count 960
    rd_bin = 0; #0.5; chk("R9 full", int'(rd_data), 960);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule